// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block holds the power-mode and core-clock-divide settings of a small controller. From them it drives one enable per clock domain: processor core, peripheral bus, PLL, crystal/timer, and interrupt wake logic. Its mode codes form a thermometer pattern. Each deeper mode clears one more bit of the code and switches off one more group of domains. The interrupt wake logic stays on in every mode.

Software writes a 7-bit control word. Bits [6:3] carry the mode code and bits [2:0] carry the divide selector CD. A rising edge on any of four interrupt request lines ends a low-power mode. The mode code returns to the run code, and a wake delay counter starts. The delay base depends on the mode being left, and the base is shifted left by CD. The `ready` flag and the core enable rise when the counter reaches zero.

While the core runs, `core_tick` is a divided clock enable that pulses once every 2^CD cycles.

Top module: `pwr_mode_seq`

## Requirements
- R1: After a synchronous reset, `mode_q` is 4'b1111 and `cd_q` is 3. All five domain enables are high and `ready` is high.
- R2: A cycle with `ctl_wr` high and no wake event loads `ctl_wdata[6:3]` into `mode_q` and `ctl_wdata[2:0]` into `cd_q`, visible after that clock edge.
- R3: Run code 4'b1111 enables core, peripheral, PLL, crystal/timer and interrupt domains.
- R4: Code 4'b1110 (halt) turns off only the core. Peripheral, PLL, crystal/timer and interrupt domains stay enabled.
- R5: Code 4'b1100 (doze) enables only the PLL, crystal/timer and interrupt domains.
- R6: Code 4'b1000 (hibernate) enables only the crystal/timer and interrupt domains.
- R7: Code 4'b0000 (off) enables only the interrupt domain, and `en_irq` is high in every mode.
- R8: Any code other than the five listed drives the same enables as the run code, while `mode_q` reads back the written code.
- R9: While `mode_q` holds a low-power code (1110, 1100, 1000 or 0000), a 0-to-1 change on any `irq` bit sets `mode_q` to 1111 after the next edge and drops `ready`. An edge while running, or a line held high, has no effect.
- R10: A wake from halt or doze keeps `ready` and `en_core` low for exactly SHORT_BASE<<CD cycles after the wake edge (default SHORT_BASE = 4).
- R11: A wake from hibernate or off keeps `ready` and `en_core` low for exactly LONG_BASE<<CD cycles (default LONG_BASE = 16).
- R12: While `en_core` is high, `core_tick` is high in the first enabled cycle and then once every 2^CD cycles. It is low whenever the core is disabled.
- R13: When a wake event and a write fall in the same cycle, the wake wins the mode field. The divide field still takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 7 | Control word: [6:3] mode code, [2:0] divide selector |
| irq | input | 4 | Interrupt request lines, wake on rising edge |
| en_core | output | 1 | Core clock domain enable |
| en_periph | output | 1 | Peripheral clock domain enable |
| en_pll | output | 1 | PLL enable |
| en_xtal | output | 1 | Crystal/timer domain enable |
| en_irq | output | 1 | Interrupt wake logic enable |
| core_tick | output | 1 | Divided core clock enable |
| ready | output | 1 | High when running and the wake delay has expired |
| mode_q | output | 4 | Current mode code |
| cd_q | output | 3 | Current divide selector |

## Verification
The assertions assume that `irq` and `ctl_wdata` are stable for a whole clock period. They also assume that a wake edge is judged against the value the line had one cycle earlier, including across reset. The stimulus changes every input only on the falling clock edge. It returns each interrupt line low before raising it again, so every intended wake is a clean single-cycle edge.

No new low-power code is written while a wake delay is still counting. The delay checks therefore measure one uninterrupted countdown against the base and CD in force at the wake edge.

// File: rtl/pms_pkg.sv
package pms_pkg;

    typedef enum logic [3:0] {
        MODE_RUN   = 4'b1111,
        MODE_HALT  = 4'b1110,
        MODE_DOZE  = 4'b1100,
        MODE_HIBER = 4'b1000,
        MODE_OFF   = 4'b0000
    } mode_e;

    typedef struct packed {
        logic core;
        logic periph;
        logic pll;
        logic xtal;
        logic irq;
    } dom_en_t;

    // Domain set for a mode code; unknown codes behave as run.
    function automatic dom_en_t mode_domains(logic [3:0] code);
        dom_en_t d;
        case (code)
            MODE_HALT:  d = '{core: 1'b0, periph: 1'b1, pll: 1'b1, xtal: 1'b1, irq: 1'b1};
            MODE_DOZE:  d = '{core: 1'b0, periph: 1'b0, pll: 1'b1, xtal: 1'b1, irq: 1'b1};
            MODE_HIBER: d = '{core: 1'b0, periph: 1'b0, pll: 1'b0, xtal: 1'b1, irq: 1'b1};
            MODE_OFF:   d = '{core: 1'b0, periph: 1'b0, pll: 1'b0, xtal: 1'b0, irq: 1'b1};
            default:    d = '{core: 1'b1, periph: 1'b1, pll: 1'b1, xtal: 1'b1, irq: 1'b1};
        endcase
        return d;
    endfunction

    // True for the modes that need the long restart delay.
    function automatic logic mode_is_deep(logic [3:0] code);
        return (code == MODE_HIBER) || (code == MODE_OFF);
    endfunction

endpackage

// File: rtl/pms_ctrl.sv
module pms_ctrl
    import pms_pkg::*;
#(
    parameter int N_IRQ      = 4,
    parameter int CD_W       = 3,
    parameter int SHORT_BASE = 4,
    parameter int LONG_BASE  = 16,
    parameter int CNT_W      = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [3:0]       wr_mode,
    input  logic [CD_W-1:0]  wr_cd,
    input  logic [N_IRQ-1:0] irq,
    output logic [3:0]       mode,
    output logic [CD_W-1:0]  cd,
    output logic             settled
);
    localparam logic [CD_W-1:0] CD_RESET = CD_W'(3);

    logic [N_IRQ-1:0] irq_prev;
    logic [CNT_W-1:0] wait_cnt;
    logic             low_power;
    logic             wake;
    logic [CNT_W-1:0] wait_load;

    always_comb begin
        low_power = (mode_domains(mode).core == 1'b0);
        wake      = low_power && (|(irq & ~irq_prev));
        wait_load = (mode_is_deep(mode) ? CNT_W'(LONG_BASE) : CNT_W'(SHORT_BASE)) << cd;
    end

    always_ff @(posedge clk) begin
        irq_prev <= irq;
        if (rst) begin
            mode     <= MODE_RUN;
            cd       <= CD_RESET;
            wait_cnt <= '0;
        end else begin
            if (wake) begin
                mode     <= MODE_RUN;
                wait_cnt <= wait_load;
            end else begin
                if (wr)
                    mode <= wr_mode;
                if (wait_cnt != '0)
                    wait_cnt <= wait_cnt - CNT_W'(1);
            end
            if (wr)
                cd <= wr_cd;
        end
    end

    assign settled = (wait_cnt == '0);
endmodule

// File: rtl/pms_decode.sv
module pms_decode
    import pms_pkg::*;
(
    input  logic [3:0] mode,
    input  logic       settled,
    output dom_en_t    dom,
    output logic       ready
);
    dom_en_t raw;

    always_comb begin
        raw      = mode_domains(mode);
        dom      = raw;
        dom.core = raw.core && settled;
        ready    = raw.core && settled;
    end
endmodule

// File: rtl/pms_cdiv.sv
module pms_cdiv #(
    parameter int CD_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [CD_W-1:0] cd,
    output logic            tick
);
    localparam int DIV_W = (1 << CD_W) - 1;

    logic [DIV_W-1:0] phase;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask = DIV_W'((1 << cd) - 1);
        tick = run && ((phase & mask) == '0);
    end

    always_ff @(posedge clk) begin
        if (rst || !run)
            phase <= '0;
        else
            phase <= phase + DIV_W'(1);
    end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pms_pkg::*;
#(
    parameter int SHORT_BASE = 4,
    parameter int LONG_BASE  = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_wr,
    input  logic [6:0] ctl_wdata,
    input  logic [3:0] irq,
    output logic       en_core,
    output logic       en_periph,
    output logic       en_pll,
    output logic       en_xtal,
    output logic       en_irq,
    output logic       core_tick,
    output logic       ready,
    output logic [3:0] mode_q,
    output logic [2:0] cd_q
);
    localparam int CD_W  = 3;
    localparam int N_IRQ = 4;
    localparam int CNT_W = $clog2(LONG_BASE + SHORT_BASE + 1) + (1 << CD_W);

    logic    settled;
    dom_en_t dom;

    pms_ctrl #(
        .N_IRQ(N_IRQ), .CD_W(CD_W), .SHORT_BASE(SHORT_BASE),
        .LONG_BASE(LONG_BASE), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .wr(ctl_wr),
        .wr_mode(ctl_wdata[6:3]), .wr_cd(ctl_wdata[2:0]), .irq(irq),
        .mode(mode_q), .cd(cd_q), .settled(settled)
    );

    pms_decode u_dec (
        .mode(mode_q), .settled(settled), .dom(dom), .ready(ready)
    );

    pms_cdiv #(.CD_W(CD_W)) u_div (
        .clk(clk), .rst(rst), .run(dom.core), .cd(cd_q), .tick(core_tick)
    );

    assign en_core   = dom.core;
    assign en_periph = dom.periph;
    assign en_pll    = dom.pll;
    assign en_xtal   = dom.xtal;
    assign en_irq    = dom.irq;
endmodule

// File: rtl/pms_chk.sv
module pms_chk (
    input logic       clk,
    input logic       rst,
    input logic       ctl_wr,
    input logic [6:0] ctl_wdata,
    input logic [3:0] irq,
    input logic       en_core,
    input logic       en_periph,
    input logic       en_pll,
    input logic       en_xtal,
    input logic       en_irq,
    input logic       core_tick,
    input logic       ready,
    input logic [3:0] mode_q,
    input logic [2:0] cd_q
);
    logic in_low;
    assign in_low = (mode_q == 4'hE) || (mode_q == 4'hC) ||
                    (mode_q == 4'h8) || (mode_q == 4'h0);

    p_write_r2: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && ((irq & ~$past(irq)) == 4'b0)) |=>
        (mode_q == $past(ctl_wdata[6:3]) && cd_q == $past(ctl_wdata[2:0])));

    p_irq_on_r7: assert property (@(posedge clk) disable iff (rst) en_irq);

    p_thermo_r6: assert property (@(posedge clk) disable iff (rst)
        (en_periph |-> en_pll) and (en_pll |-> en_xtal) and (en_xtal |-> en_irq));

    p_wake_r9: assert property (@(posedge clk) disable iff (rst)
        (in_low && ((irq & ~$past(irq)) != 4'b0)) |=> (mode_q == 4'hF && !ready));

    p_tick_core_r12: assert property (@(posedge clk) disable iff (rst)
        core_tick |-> en_core);
endmodule

bind pwr_mode_seq pms_chk u_chk (.*);

// File: tb/sim_pwr_mode_seq.sv
module sim_pwr_mode_seq;
    localparam int SB = 4;
    localparam int LB = 16;

    logic       clk = 1'b0;
    logic       rst;
    logic       ctl_wr;
    logic [6:0] ctl_wdata;
    logic [3:0] irq;
    logic       en_core, en_periph, en_pll, en_xtal, en_irq, core_tick, ready;
    logic [3:0] mode_q;
    logic [2:0] cd_q;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // behavioural reference state
    int m_mode, m_cd, m_cnt, m_div;
    logic [3:0] m_irqd;

    always #5 clk = ~clk;

    pwr_mode_seq u0 (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected enables {core,periph,pll,xtal,irq} from the mode table
    function automatic int exp_dom(int md, int cnt);
        int d;
        case (md)
            'hE: d = 5'b01111;
            'hC: d = 5'b00111;
            'h8: d = 5'b00011;
            'h0: d = 5'b00001;
            default: d = (cnt == 0) ? 5'b11111 : 5'b01111;
        endcase
        return d;
    endfunction

    function automatic bit m_low(int md);
        return md == 'hE || md == 'hC || md == 'h8 || md == 'h0;
    endfunction

    always @(posedge clk) begin
        int d;
        bit rise;
        cycles++;
        d = exp_dom(m_mode, m_cnt);
        rise = |(irq & ~m_irqd);
        m_irqd = irq;
        if (rst) begin
            m_mode = 'hF; m_cd = 3; m_cnt = 0; m_div = 0;
        end else begin
            m_div = d[4] ? (m_div + 1) % 128 : 0;
            if (rise && m_low(m_mode)) begin
                m_cnt = ((m_mode == 'h8 || m_mode == 'h0) ? LB : SB) << m_cd;
                m_mode = 'hF;
            end else begin
                if (ctl_wr) m_mode = int'(ctl_wdata[6:3]);
                if (m_cnt > 0) m_cnt--;
            end
            if (ctl_wr) m_cd = int'(ctl_wdata[2:0]);
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        int d;
        bit etick;
        if (!rst && cycles > 1) begin
            d = exp_dom(m_mode, m_cnt);
            etick = d[4] && ((m_div % (1 << m_cd)) == 0);
            check({en_core, en_periph, en_pll, en_xtal, en_irq} == d[4:0], "R3 model enables",
                  {en_core, en_periph, en_pll, en_xtal, en_irq}, d);
            check(ready == d[4], "R10 model ready", ready, d[4]);
            check(core_tick == etick, "R12 model tick", core_tick, etick);
            check(mode_q == m_mode[3:0] && cd_q == m_cd[2:0], "R2 model regs",
                  {mode_q, cd_q}, {m_mode[3:0], m_cd[2:0]});
        end
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic wr(input logic [3:0] md, input logic [2:0] cdv);
        ctl_wr = 1'b1; ctl_wdata = {md, cdv};
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic doms(input int exp, input string req);
        check({en_core, en_periph, en_pll, en_xtal, en_irq} == exp[4:0], req,
              {en_core, en_periph, en_pll, en_xtal, en_irq}, exp);
    endtask

    // pulse an irq line, then count cycles until ready
    task automatic wake_and_time(input int line, input int exp_delay, input string req);
        int n = 0;
        irq[line] = 1'b1;
        @(negedge clk);
        irq[line] = 1'b0;
        check(mode_q == 4'hF && !ready, "R9 wake forces run", {mode_q, ready}, 5'b11110);
        while (!ready && n < 5000) begin
            n++;
            @(negedge clk);
        end
        check(n == exp_delay, req, n, exp_delay);
    endtask

    initial begin
        rst = 1'b1; ctl_wr = 1'b0; ctl_wdata = '0; irq = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(mode_q == 4'hF && cd_q == 3 && ready, "R1 reset state", {mode_q, cd_q, ready}, 8'hF7);
        doms(5'b11111, "R1 R3 run enables");

        // halt, CD=0
        wr(4'hE, 3'd0);
        check(mode_q == 4'hE && cd_q == 0, "R2 write fields", {mode_q, cd_q}, 7'h70);
        doms(5'b01111, "R4 halt enables");
        wake_and_time(0, SB << 0, "R10 halt wake delay");

        // doze, CD=2
        wr(4'hC, 3'd2);
        doms(5'b00111, "R5 doze enables");
        wake_and_time(1, SB << 2, "R10 doze wake delay");

        // hibernate, CD=1
        wr(4'h8, 3'd1);
        doms(5'b00011, "R6 hibernate enables");
        wake_and_time(2, LB << 1, "R11 hibernate wake delay");

        // off, CD=7
        wr(4'h0, 3'd7);
        doms(5'b00001, "R7 off enables");
        wake_and_time(3, LB << 7, "R11 off wake delay");

        // undefined code behaves as run; irq edge ignored
        wr(4'hA, 3'd2);
        doms(5'b11111, "R8 undefined code enables");
        check(mode_q == 4'hA, "R8 code reads back", mode_q, 4'hA);
        irq[0] = 1'b1;
        @(negedge clk);
        irq[0] = 1'b0;
        @(negedge clk);
        check(mode_q == 4'hA && ready, "R9 edge ignored while running", {mode_q, ready}, 5'h15);

        // tick rate with CD=2 over 16 cycles
        begin
            int t = 0;
            wr(4'hF, 3'd2);
            for (int i = 0; i < 16; i++) begin
                t += core_tick;
                @(negedge clk);
            end
            check(t == 4, "R12 tick count CD=2", t, 4);
        end

        // held-high line does not wake
        irq[1] = 1'b1;
        @(negedge clk);
        wr(4'h8, 3'd0);
        repeat (4) @(negedge clk);
        check(mode_q == 4'h8 && !core_tick, "R9 held level no wake", {mode_q, core_tick}, 5'h10);
        irq[1] = 1'b0;
        @(negedge clk);

        // wake and write in the same cycle
        wr(4'h0, 3'd1);
        irq[2] = 1'b1; ctl_wr = 1'b1; ctl_wdata = {4'hC, 3'd5};
        @(negedge clk);
        irq[2] = 1'b0; ctl_wr = 1'b0;
        check(mode_q == 4'hF && cd_q == 5, "R13 wake beats write", {mode_q, cd_q}, 7'h7D);
        while (!ready) @(negedge clk);

        // reset mid-operation
        wr(4'hC, 3'd6);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(mode_q == 4'hF && cd_q == 3 && ready, "R1 reset re-entry", {mode_q, cd_q, ready}, 8'hF7);

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule